// File: doc/BRIEF.md
# Parity Error Control and Status Register

This block is a special-purpose register that controls parity checking on three on-chip memory arrays and records what the checking finds. Array 0 is the instruction cache with its tags, array 1 is the data cache with its tags, and array 2 is the second-level cache tags. Each array has its own enable bit and its own sticky status bit. Each array read presents its data, its stored parity bit and a valid strobe. The block forms the even parity over the data and the stored bit. A nonzero result on a valid read of an enabled array sets that array's status bit. It also latches a machine-check request, which is imprecise and cannot be recovered from.

Software reaches the register through move-to and move-from special-register accesses. The access carries a 10-bit register number whose two 5-bit halves arrive swapped. The block swaps them back and compares the result with 1016. A write loads the enable bits from the write data and, whatever that data holds, wipes all three status bits. A read returns the enables and the status in one word. The machine-check request leaves the block only while the machine-check enable bit of the machine state is set. Once latched, the request stays pending until hard reset.

Top module: `parity_ctl_reg`

## Requirements
- R1: After hard reset (rst_n low), all enable bits, all status bits and the pending machine check are zero. A read therefore returns 0 and mchk_req is 0.
- R2: An access hits only when {spr_enc[4:0], spr_enc[9:5]} equals 1016, which means spr_enc = 10'h31F. Any other value, including the unswapped 10'h3F8, changes no state on a write and returns 0 on a read.
- R3: On a hitting read, spr_rdata bit 10-k holds the enable bit of array k and bit 6-k holds the status bit of array k, for k = 0, 1, 2. Every other bit reads 0.
- R4: A hitting write loads the enable bit of array k from spr_wdata bit 10-k. The new enables apply to reads from the next cycle on, and all other write-data bits are ignored.
- R5: A read of array k flags a parity error when arr_rd_vld[k] is 1 and the XOR of arr_rd_data[k*DW +: DW] and arr_rd_par[k] is 1.
- R6: A flagged error on an enabled array sets that array's status bit at the next clock edge. The bit stays set until a hitting write or a reset.
- R7: A flagged error on an array whose enable bit is 0 neither sets status nor raises a machine check.
- R8: Any hitting write clears all three status bits, whatever the data written, including ones in status bit positions.
- R9: When an enabled array flags an error in the same cycle as a hitting write, its status bit is set after that edge. The enables that apply in that cycle are the ones held before the write.
- R10: An enabled error latches a pending machine check that holds until hard reset, unaffected by writes. mchk_req equals the pending flag ANDed with msr_me.
- R11: An array read with its valid bit at 0 has no effect, whatever its data and parity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hard reset, active low, synchronous |
| arr_rd_vld | input | 3 | Per-array read valid strobe |
| arr_rd_data | input | 3*DW | Read data; array k in bits [k*DW +: DW] |
| arr_rd_par | input | 3 | Stored parity bit per array |
| spr_enc | input | 10 | Register number with its 5-bit halves swapped |
| spr_wr | input | 1 | Move-to special register strobe |
| spr_rd | input | 1 | Move-from special register strobe |
| spr_wdata | input | XLEN | Write data |
| spr_rdata | output | XLEN | Read data, combinational from the held state |
| msr_me | input | 1 | Machine-check enable from the machine state |
| mchk_req | output | 1 | Machine-check request |

## Verification
The assertions assume that the strobes, the address field and the array inputs are known in every cycle after reset. They also assume that a write and an array error may coincide in the same cycle, and that is the only ordering conflict the register resolves. The bench changes every input just after a falling edge and clears the strobes one cycle later, so each access or array read covers exactly one rising edge. Read data is sampled shortly after the falling edge, when only the combinational read path is active.

// File: rtl/pcr_pkg.sv
package pcr_pkg;
    localparam int NARR = 3;

    typedef struct packed {
        logic [NARR-1:0] en;
        logic [NARR-1:0] sts;
        logic            pend;
    } pcr_state_t;
endpackage

// File: rtl/pcr_addr_dec.sv
module pcr_addr_dec #(
    parameter int HALF     = 5,
    parameter int SPR_ADDR = 1016
) (
    input  logic [2*HALF-1:0] enc,
    input  logic              acc,
    output logic              hit
);
    localparam int AW = 2 * HALF;
    localparam logic [AW-1:0] ADDR_V = AW'(SPR_ADDR);

    logic [AW-1:0] num;

    always_comb begin
        num = {enc[HALF-1:0], enc[AW-1:HALF]};
        hit = acc && (num == ADDR_V);
    end
endmodule

// File: rtl/pcr_par_chk.sv
module pcr_par_chk #(
    parameter int DW = 8
) (
    input  logic          vld,
    input  logic [DW-1:0] data,
    input  logic          par,
    output logic          err
);
    always_comb begin
        err = vld & (^{data, par});
    end
endmodule

// File: rtl/parity_ctl_reg.sv
module parity_ctl_reg
    import pcr_pkg::*;
#(
    parameter int DW       = 8,
    parameter int XLEN     = 32,
    parameter int HALF     = 5,
    parameter int SPR_ADDR = 1016,
    parameter int EN_MSB   = 10,
    parameter int STS_MSB  = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NARR-1:0]      arr_rd_vld,
    input  logic [NARR*DW-1:0]   arr_rd_data,
    input  logic [NARR-1:0]      arr_rd_par,
    input  logic [2*HALF-1:0]    spr_enc,
    input  logic                 spr_wr,
    input  logic                 spr_rd,
    input  logic [XLEN-1:0]      spr_wdata,
    output logic [XLEN-1:0]      spr_rdata,
    input  logic                 msr_me,
    output logic                 mchk_req
);
    pcr_state_t st_d, st_q;
    logic       wr_hit, rd_hit;
    logic [NARR-1:0] err_v;
    logic [NARR-1:0] hit_err;

    pcr_addr_dec #(.HALF(HALF), .SPR_ADDR(SPR_ADDR)) u_wr_dec (
        .enc(spr_enc), .acc(spr_wr), .hit(wr_hit)
    );
    pcr_addr_dec #(.HALF(HALF), .SPR_ADDR(SPR_ADDR)) u_rd_dec (
        .enc(spr_enc), .acc(spr_rd), .hit(rd_hit)
    );

    for (genvar g = 0; g < NARR; g++) begin : g_chk
        pcr_par_chk #(.DW(DW)) u_chk (
            .vld (arr_rd_vld[g]),
            .data(arr_rd_data[g*DW +: DW]),
            .par (arr_rd_par[g]),
            .err (err_v[g])
        );
    end

    always_comb begin
        st_d    = st_q;
        hit_err = err_v & st_q.en;
        if (wr_hit) begin
            for (int k = 0; k < NARR; k++) begin
                st_d.en[k] = spr_wdata[EN_MSB-k];
            end
            st_d.sts = '0;
        end
        st_d.sts  = st_d.sts | hit_err;
        st_d.pend = st_q.pend | (|hit_err);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        spr_rdata = '0;
        if (rd_hit) begin
            for (int k = 0; k < NARR; k++) begin
                spr_rdata[EN_MSB-k]  = st_q.en[k];
                spr_rdata[STS_MSB-k] = st_q.sts[k];
            end
        end
        mchk_req = st_q.pend & msr_me;
    end

    // R6: status bits are sticky while no write hits
    a_r6_sts_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> ((st_q.sts & $past(st_q.sts)) == $past(st_q.sts)));

    // R7: a disabled array's status bit cannot change without a write
    a_r7_masked: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> ((st_q.sts & ~$past(st_q.en)) == ($past(st_q.sts) & ~$past(st_q.en))));

    // R8: an error-free write leaves no status bit
    a_r8_wr_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && (err_v == '0)) |=> (st_q.sts == '0));

    // R9: an enabled error in a write cycle survives the clear
    a_r9_err_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && ((err_v & st_q.en) != '0)) |=> (st_q.sts != '0));

    // R10: pending machine check holds until reset
    a_r10_pend_hold: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pend |=> st_q.pend);

    // R10: request leaves only with machine-check enable
    a_r10_me_gate: assert property (@(posedge clk) disable iff (!rst_n)
        mchk_req |-> msr_me);

    // R2: a read that misses returns zero
    a_r2_rd_miss: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_hit |-> (spr_rdata == '0));
endmodule

// File: tb/parity_ctl_reg_tb.sv
`timescale 1ns/1ps
module parity_ctl_reg_tb;
    localparam int DW = 8;
    localparam int NA = 3;
    localparam logic [9:0] ENC_OK  = 10'h31F;
    localparam logic [9:0] ENC_BAD = 10'h3F8;
    localparam logic [31:0] EN_ALL = 32'h0000_0700;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NA-1:0]     arr_rd_vld = '0;
    logic [NA*DW-1:0]  arr_rd_data = '0;
    logic [NA-1:0]     arr_rd_par = '0;
    logic [9:0]        spr_enc = '0;
    logic              spr_wr = 1'b0;
    logic              spr_rd = 1'b0;
    logic [31:0]       spr_wdata = '0;
    logic [31:0]       spr_rdata;
    logic              msr_me = 1'b0;
    logic              mchk_req;

    int checks = 0;
    int errors = 0;

    parity_ctl_reg u_dut (
        .clk(clk), .rst_n(rst_n),
        .arr_rd_vld(arr_rd_vld), .arr_rd_data(arr_rd_data), .arr_rd_par(arr_rd_par),
        .spr_enc(spr_enc), .spr_wr(spr_wr), .spr_rd(spr_rd),
        .spr_wdata(spr_wdata), .spr_rdata(spr_rdata),
        .msr_me(msr_me), .mchk_req(mchk_req)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic spr_write(input logic [9:0] enc, input logic [31:0] d);
        @(negedge clk);
        spr_enc = enc; spr_wdata = d; spr_wr = 1'b1;
        @(negedge clk);
        spr_wr = 1'b0;
    endtask

    task automatic spr_read(input logic [9:0] enc, output logic [31:0] v);
        @(negedge clk);
        spr_enc = enc; spr_rd = 1'b1;
        #1;
        v = spr_rdata;
        spr_rd = 1'b0;
    endtask

    task automatic arr_read(input int k, input logic [DW-1:0] d, input logic p, input logic v);
        @(negedge clk);
        arr_rd_vld = '0; arr_rd_vld[k] = v;
        arr_rd_data[k*DW +: DW] = d;
        arr_rd_par[k] = p;
        @(negedge clk);
        arr_rd_vld = '0;
    endtask

    function automatic logic [31:0] sts_bit(input int k);
        logic [31:0] r = '0;
        r[6-k] = 1'b1;
        return r;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] rv;
        do_reset();
        // R1 reset state
        spr_read(ENC_OK, rv);
        check("R1 reset read", rv, 32'h0);
        check("R1 reset mchk", {31'b0, mchk_req}, 32'h0);

        // R7 disabled arrays: exhaustive sweep, nothing recorded
        msr_me = 1'b1;
        for (int k = 0; k < NA; k++) begin
            for (int d = 0; d < 256; d++) begin
                for (int p = 0; p < 2; p++) begin
                    arr_read(k, DW'(d), p[0], 1'b1);
                end
            end
            spr_read(ENC_OK, rv);
            check("R7 disabled status", rv, 32'h0);
            check("R7 disabled mchk", {31'b0, mchk_req}, 32'h0);
        end

        // R4/R3 enables from write data, other bits ignored
        spr_write(ENC_OK, 32'hFFFF_FFFF);
        spr_read(ENC_OK, rv);
        check("R3 R4 enable readback", rv, EN_ALL);

        // R11 invalid reads ignored
        for (int k = 0; k < NA; k++) begin
            for (int d = 0; d < 256; d++) begin
                arr_read(k, DW'(d), ~(^DW'(d)), 1'b0);
            end
        end
        spr_read(ENC_OK, rv);
        check("R11 invalid ignored", rv, EN_ALL);
        check("R11 invalid mchk", {31'b0, mchk_req}, 32'h0);

        // R2 decode
        spr_write(ENC_BAD, 32'h0);
        spr_read(ENC_OK, rv);
        check("R2 unswapped write ignored", rv, EN_ALL);
        spr_read(ENC_BAD, rv);
        check("R2 unswapped read zero", rv, 32'h0);
        spr_read(10'h31E, rv);
        check("R2 near address read zero", rv, 32'h0);

        // R5/R6/R8 exhaustive enabled sweep, me low
        msr_me = 1'b0;
        for (int k = 0; k < NA; k++) begin
            for (int d = 0; d < 256; d++) begin
                for (int p = 0; p < 2; p++) begin
                    logic e;
                    e = (^DW'(d)) ^ p[0];
                    arr_read(k, DW'(d), p[0], 1'b1);
                    spr_read(ENC_OK, rv);
                    check("R5 R6 status after read", rv, EN_ALL | (e ? sts_bit(k) : 32'h0));
                    if (e) begin
                        spr_read(ENC_OK, rv);
                        check("R6 status sticky", rv, EN_ALL | sts_bit(k));
                        spr_write(ENC_OK, EN_ALL);
                        spr_read(ENC_OK, rv);
                        check("R8 write clears", rv, EN_ALL);
                    end
                end
            end
        end
        check("R10 gated by me", {31'b0, mchk_req}, 32'h0);
        @(negedge clk);
        msr_me = 1'b1;
        #1;
        check("R10 request with me", {31'b0, mchk_req}, 32'h1);

        // R8 clear regardless of data; all three set first
        for (int k = 0; k < NA; k++) arr_read(k, 8'h01, 1'b0, 1'b1);
        spr_read(ENC_OK, rv);
        check("R6 all status set", rv, 32'h0000_0770);
        spr_write(ENC_OK, 32'h0000_0070);
        spr_read(ENC_OK, rv);
        check("R8 status-ones write clears", rv, 32'h0);
        check("R10 pending survives write", {31'b0, mchk_req}, 32'h1);

        // R9 error and write in same cycle; old enables apply
        spr_write(ENC_OK, 32'h0000_0200);
        @(negedge clk);
        arr_rd_vld = 3'b111;
        arr_rd_data = {8'h01, 8'h01, 8'h01};
        arr_rd_par = 3'b000;
        spr_enc = ENC_OK; spr_wdata = EN_ALL; spr_wr = 1'b1;
        @(negedge clk);
        arr_rd_vld = '0; spr_wr = 1'b0;
        spr_read(ENC_OK, rv);
        check("R9 error beats clear", rv, EN_ALL | sts_bit(1));

        // R7 per-array enable selection
        spr_write(ENC_OK, 32'h0000_0100);
        for (int k = 0; k < NA; k++) arr_read(k, 8'h80, 1'b0, 1'b1);
        spr_read(ENC_OK, rv);
        check("R7 only enabled array sets", rv, 32'h0000_0100 | sts_bit(2));

        // R10/R1 pending cleared only by reset
        do_reset();
        #1;
        check("R10 reset clears mchk", {31'b0, mchk_req}, 32'h0);
        spr_read(ENC_OK, rv);
        check("R1 second reset read", rv, 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule